// File: doc/BRIEF.md
# PC-indexed stride prefetch engine

This block observes a stream of cache access events. Each event carries a full byte address, the program counter of the load, a miss flag and an instruction/data flag. For every PC it keeps a small history entry in a set-associative table: the last byte address seen, the last stride and a 2-bit confidence counter. Once a PC shows a steady stride, the block generates prefetch line addresses one or more strides ahead. It places them in a short FIFO that the cache's miss path drains through a valid/ready handshake.

Instruction fetches carry no useful stride history. For these, a mode input switches the block to plain next-N-lines prefetching. Two filter inputs limit training and prefetching to misses only, or to data accesses only. A writeback input removes any queued prefetch to the same line, so a prefetch that has gone stale cannot overtake newer data. Each request can carry the PC that triggered it, so a prefetcher further down the hierarchy can train on it.

Top module: `stride_pf`

## Requirements
- R1: After reset `pf_valid_o` is low and every table entry is invalid, so the first access of any PC produces no prefetch.
- R2: Training uses the unmasked byte address. A PC stepping by 48 bytes with 64-byte lines is treated as a constant stride.
- R3: A PC's first access allocates an entry (confidence 0, stride unknown). The second access records the stride. Each later matching stride raises confidence, saturating at 3. Whenever confidence after the update is 2 or more and the stride is non-zero, the block requests lines `line(addr + k*stride)` for k = 1..DEGREE, in order of k. Here `line(x)` clears the low log2(LINE_BYTES) bits.
- R4: A single mispredict at non-zero confidence keeps the stride and confidence, and still prefetches with the kept stride. A second consecutive mispredict sets confidence to 0 and adopts the new stride. A mispredict at confidence 0 adopts the new stride at once.
- R5: The table is indexed by PC bits [2 +: log2(SETS)] and has WAYS ways per set. A tag miss fills an invalid way first; otherwise it evicts the least recently used way of that set.
- R6: When `cfg_inst_nblk_i` is 1, an instruction access does no training and requests `line(addr) + k*LINE_BYTES` for k = 1..DEGREE.
- R7: When `cfg_miss_only_i` is 1, an access with `acc_miss_i` = 0 neither trains nor prefetches.
- R8: When `cfg_data_only_i` is 1, an access with `acc_inst_i` = 1 neither trains nor prefetches.
- R9: Requests leave in the order they were generated. While `pf_ready_i` is low the head address holds. A generated line that finds the queue full waits, and is not lost.
- R10: A writeback (`wb_valid_i`) to a line drops a queued, not-yet-accepted request for that line, and also a candidate for that line in the same cycle.
- R11: A generated line already present in the queue is not enqueued a second time.
- R12: When `cfg_tag_pc_i` is 1, each request presents the triggering PC on `pf_pc_o` with `pf_pc_valid_o` high. When it is 0, `pf_pc_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_miss_only_i | input | 1 | Train and prefetch on misses only |
| cfg_data_only_i | input | 1 | Train and prefetch on data accesses only |
| cfg_inst_nblk_i | input | 1 | Instruction accesses use next-N-lines mode |
| cfg_tag_pc_i | input | 1 | Attach the triggering PC to requests |
| acc_valid_i | input | 1 | Access event valid |
| acc_addr_i | input | ADDR_W | Byte address of the access |
| acc_pc_i | input | PC_W | PC of the access |
| acc_miss_i | input | 1 | Access missed in the cache |
| acc_inst_i | input | 1 | Access is an instruction fetch |
| wb_valid_i | input | 1 | Writeback observed |
| wb_addr_i | input | ADDR_W | Writeback byte address |
| pf_valid_o | output | 1 | Prefetch request valid |
| pf_ready_i | input | 1 | Prefetch request accepted |
| pf_addr_o | output | ADDR_W | Line-aligned prefetch address |
| pf_pc_o | output | PC_W | Triggering PC, or zero |
| pf_pc_valid_o | output | 1 | `pf_pc_o` is meaningful |

## Verification
Some properties are checked on every cycle. Outgoing addresses must be line aligned. A stalled head must hold its address unless a writeback squashes it, and a squashed head must not reappear. A waiting candidate must stay put until the queue takes or drops it. The bench scenarios cover the rest, because these behaviours depend on history that a single-cycle property cannot see. That history includes the confidence sequence that starts issuing on the fourth access, the two-strike rule for mispredicts and LRU eviction between PCs sharing a set. The bench also covers the miss and data filters, the next-N-lines mode, duplicate suppression and PC tagging.

// File: rtl/stride_pf_pkg.sv
`timescale 1ns/1ps
package stride_pf_pkg;
  localparam int CONF_W = 2;
  localparam logic [CONF_W-1:0] CONF_MAX   = 2'd3;
  localparam logic [CONF_W-1:0] CONF_ISSUE = 2'd2;

  function automatic logic [CONF_W-1:0] conf_up(input logic [CONF_W-1:0] c);
    return (c == CONF_MAX) ? c : c + 2'd1;
  endfunction
endpackage

// File: rtl/stride_pf_table.sv
`timescale 1ns/1ps
module stride_pf_table
  import stride_pf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PC_W   = 32,
  parameter int SETS   = 4,
  parameter int WAYS   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              trig_o,
  output logic [ADDR_W-1:0] step_o
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = PC_W - IDX_W;
  localparam int AGE_W = $clog2(WAYS);

  logic              v_q      [SETS][WAYS];
  logic [TAG_W-1:0]  tag_q    [SETS][WAYS];
  logic [ADDR_W-1:0] last_q   [SETS][WAYS];
  logic [ADDR_W-1:0] stride_q [SETS][WAYS];
  logic [CONF_W-1:0] conf_q   [SETS][WAYS];
  logic              mp_q     [SETS][WAYS];
  logic [AGE_W-1:0]  age_q    [SETS][WAYS];

  logic [IDX_W-1:0]  set_idx;
  logic [TAG_W-1:0]  tag;
  logic              hit, found;
  logic [AGE_W-1:0]  hit_way, victim, tw;
  logic [ADDR_W-1:0] e_last, e_stride, delta, n_stride;
  logic [CONF_W-1:0] e_conf, n_conf;
  logic              e_mp, n_mp;

  assign set_idx = pc_i[2 +: IDX_W];
  assign tag     = {pc_i[PC_W-1:IDX_W+2], pc_i[1:0]};

  always_comb begin
    hit = 1'b0;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (v_q[set_idx][w] && tag_q[set_idx][w] == tag) begin
        hit = 1'b1;
        hit_way = AGE_W'(w);
      end
    end
    found = 1'b0;
    victim = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!v_q[set_idx][w] && !found) begin
        victim = AGE_W'(w);
        found = 1'b1;
      end
    end
    if (!found) begin
      for (int w = 0; w < WAYS; w++) begin
        if (age_q[set_idx][w] == AGE_W'(WAYS-1)) victim = AGE_W'(w);
      end
    end
  end

  assign tw       = hit ? hit_way : victim;
  assign e_last   = last_q[set_idx][hit_way];
  assign e_stride = stride_q[set_idx][hit_way];
  assign e_conf   = conf_q[set_idx][hit_way];
  assign e_mp     = mp_q[set_idx][hit_way];
  assign delta    = addr_i - e_last;

  // two-strike rule: first mispredict at nonzero confidence is tolerated
  always_comb begin
    if (delta == e_stride) begin
      n_conf = conf_up(e_conf);
      n_stride = e_stride;
      n_mp = 1'b0;
    end else if (e_conf == '0) begin
      n_conf = '0;
      n_stride = delta;
      n_mp = 1'b0;
    end else if (!e_mp) begin
      n_conf = e_conf;
      n_stride = e_stride;
      n_mp = 1'b1;
    end else begin
      n_conf = '0;
      n_stride = delta;
      n_mp = 1'b0;
    end
  end

  assign trig_o = en_i && hit && (n_conf >= CONF_ISSUE) && (n_stride != '0);
  assign step_o = n_stride;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          v_q[s][w]      <= 1'b0;
          tag_q[s][w]    <= '0;
          last_q[s][w]   <= '0;
          stride_q[s][w] <= '0;
          conf_q[s][w]   <= '0;
          mp_q[s][w]     <= 1'b0;
          age_q[s][w]    <= AGE_W'(w);
        end
      end
    end else if (en_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (AGE_W'(w) == tw) age_q[set_idx][w] <= '0;
        else if (age_q[set_idx][w] < age_q[set_idx][tw])
          age_q[set_idx][w] <= age_q[set_idx][w] + AGE_W'(1);
      end
      v_q[set_idx][tw]    <= 1'b1;
      tag_q[set_idx][tw]  <= tag;
      last_q[set_idx][tw] <= addr_i;
      if (hit) begin
        stride_q[set_idx][tw] <= n_stride;
        conf_q[set_idx][tw]   <= n_conf;
        mp_q[set_idx][tw]     <= n_mp;
      end else begin
        stride_q[set_idx][tw] <= '0;
        conf_q[set_idx][tw]   <= '0;
        mp_q[set_idx][tw]     <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/stride_pf_gen.sv
`timescale 1ns/1ps
module stride_pf_gen #(
  parameter int ADDR_W     = 32,
  parameter int PC_W       = 32,
  parameter int LINE_BYTES = 64,
  parameter int DEGREE     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] step_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic              done_i,
  output logic              cand_valid_o,
  output logic [ADDR_W-1:0] cand_addr_o,
  output logic [PC_W-1:0]   cand_pc_o
);
  localparam int CNT_W = $clog2(DEGREE + 1);
  localparam logic [ADDR_W-1:0] LINE_MASK = ~ADDR_W'(LINE_BYTES - 1);

  logic              active_q;
  logic [ADDR_W-1:0] next_q, step_q;
  logic [PC_W-1:0]   pc_q;
  logic [CNT_W-1:0]  left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      next_q   <= '0;
      step_q   <= '0;
      pc_q     <= '0;
      left_q   <= '0;
    end else if (trig_i) begin
      active_q <= 1'b1;
      next_q   <= base_i + step_i;
      step_q   <= step_i;
      pc_q     <= pc_i;
      left_q   <= CNT_W'(DEGREE);
    end else if (active_q && done_i) begin
      next_q <= next_q + step_q;
      left_q <= left_q - CNT_W'(1);
      if (left_q == CNT_W'(1)) active_q <= 1'b0;
    end
  end

  assign cand_valid_o = active_q;
  assign cand_addr_o  = next_q & LINE_MASK;
  assign cand_pc_o    = pc_q;
endmodule

// File: rtl/stride_pf_queue.sv
`timescale 1ns/1ps
module stride_pf_queue #(
  parameter int ADDR_W     = 32,
  parameter int PC_W       = 32,
  parameter int LINE_BYTES = 64,
  parameter int DEPTH      = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cand_valid_i,
  input  logic [ADDR_W-1:0] cand_addr_i,
  input  logic [PC_W-1:0]   cand_pc_i,
  output logic              done_o,
  input  logic              wb_valid_i,
  input  logic [ADDR_W-1:0] wb_addr_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [PC_W-1:0]   pc_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [ADDR_W-1:0] LINE_MASK = ~ADDR_W'(LINE_BYTES - 1);

  logic [DEPTH-1:0]  q_v, n_v;
  logic [ADDR_W-1:0] q_a [DEPTH];
  logic [ADDR_W-1:0] n_a [DEPTH];
  logic [PC_W-1:0]   q_p [DEPTH];
  logic [PC_W-1:0]   n_p [DEPTH];
  logic [ADDR_W-1:0] wb_line;
  logic              pop, dup, wb_cand, room, push, keep;
  int                wp;

  assign wb_line = wb_addr_i & LINE_MASK;
  assign pop     = q_v[0] && ready_i;
  assign wb_cand = wb_valid_i && (cand_addr_i == wb_line);

  // compact surviving entries toward the head, then append
  always_comb begin
    n_v = '0;
    for (int i = 0; i < DEPTH; i++) begin
      n_a[i] = '0;
      n_p[i] = '0;
    end
    wp  = 0;
    dup = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      keep = q_v[i] && !(i == 0 && pop) && !(wb_valid_i && q_a[i] == wb_line);
      if (keep) begin
        if (q_a[i] == cand_addr_i) dup = 1'b1;
        n_v[PTR_W'(wp)] = 1'b1;
        n_a[PTR_W'(wp)] = q_a[i];
        n_p[PTR_W'(wp)] = q_p[i];
        wp = wp + 1;
      end
    end
    room   = (wp < DEPTH);
    push   = cand_valid_i && room && !dup && !wb_cand;
    done_o = cand_valid_i && (dup || wb_cand || room);
    if (push) begin
      n_v[PTR_W'(wp)] = 1'b1;
      n_a[PTR_W'(wp)] = cand_addr_i;
      n_p[PTR_W'(wp)] = cand_pc_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_v <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        q_a[i] <= '0;
        q_p[i] <= '0;
      end
    end else begin
      q_v <= n_v;
      for (int i = 0; i < DEPTH; i++) begin
        q_a[i] <= n_a[i];
        q_p[i] <= n_p[i];
      end
    end
  end

  assign valid_o = q_v[0];
  assign addr_o  = q_a[0];
  assign pc_o    = q_p[0];
endmodule

// File: rtl/stride_pf.sv
`timescale 1ns/1ps
module stride_pf #(
  parameter int ADDR_W     = 32,
  parameter int PC_W       = 32,
  parameter int SETS       = 4,
  parameter int WAYS       = 2,
  parameter int LINE_BYTES = 64,
  parameter int DEGREE     = 2,
  parameter int DEPTH      = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_miss_only_i,
  input  logic              cfg_data_only_i,
  input  logic              cfg_inst_nblk_i,
  input  logic              cfg_tag_pc_i,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [PC_W-1:0]   acc_pc_i,
  input  logic              acc_miss_i,
  input  logic              acc_inst_i,
  input  logic              wb_valid_i,
  input  logic [ADDR_W-1:0] wb_addr_i,
  output logic              pf_valid_o,
  input  logic              pf_ready_i,
  output logic [ADDR_W-1:0] pf_addr_o,
  output logic [PC_W-1:0]   pf_pc_o,
  output logic              pf_pc_valid_o
);
  localparam logic [ADDR_W-1:0] LINE_MASK = ~ADDR_W'(LINE_BYTES - 1);

  logic              acc_ok, nblk, stride_en, tab_trig, gen_trig;
  logic [ADDR_W-1:0] tab_step, gen_base, gen_step, cand_addr;
  logic [PC_W-1:0]   cand_pc, q_pc;
  logic              cand_valid, cand_done;

  assign acc_ok    = acc_valid_i && !(cfg_miss_only_i && !acc_miss_i)
                                 && !(cfg_data_only_i && acc_inst_i);
  assign nblk      = acc_ok && acc_inst_i && cfg_inst_nblk_i;
  assign stride_en = acc_ok && !nblk;

  stride_pf_table #(
    .ADDR_W(ADDR_W), .PC_W(PC_W), .SETS(SETS), .WAYS(WAYS)
  ) u_table (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(stride_en),
    .pc_i(acc_pc_i), .addr_i(acc_addr_i),
    .trig_o(tab_trig), .step_o(tab_step)
  );

  assign gen_trig = nblk || tab_trig;
  assign gen_base = nblk ? (acc_addr_i & LINE_MASK) : acc_addr_i;
  assign gen_step = nblk ? ADDR_W'(LINE_BYTES) : tab_step;

  stride_pf_gen #(
    .ADDR_W(ADDR_W), .PC_W(PC_W), .LINE_BYTES(LINE_BYTES), .DEGREE(DEGREE)
  ) u_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(gen_trig),
    .base_i(gen_base), .step_i(gen_step), .pc_i(acc_pc_i),
    .done_i(cand_done), .cand_valid_o(cand_valid),
    .cand_addr_o(cand_addr), .cand_pc_o(cand_pc)
  );

  stride_pf_queue #(
    .ADDR_W(ADDR_W), .PC_W(PC_W), .LINE_BYTES(LINE_BYTES), .DEPTH(DEPTH)
  ) u_queue (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cand_valid_i(cand_valid), .cand_addr_i(cand_addr), .cand_pc_i(cand_pc),
    .done_o(cand_done), .wb_valid_i(wb_valid_i), .wb_addr_i(wb_addr_i),
    .ready_i(pf_ready_i), .valid_o(pf_valid_o), .addr_o(pf_addr_o), .pc_o(q_pc)
  );

  assign pf_pc_valid_o = pf_valid_o && cfg_tag_pc_i;
  assign pf_pc_o       = cfg_tag_pc_i ? q_pc : '0;
endmodule

// File: rtl/stride_pf_chk.sv
`timescale 1ns/1ps
module stride_pf_chk #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pf_valid_i,
  input logic              pf_ready_i,
  input logic [ADDR_W-1:0] pf_addr_i,
  input logic              wb_valid_i,
  input logic [ADDR_W-1:0] wb_addr_i,
  input logic              cand_valid_i,
  input logic [ADDR_W-1:0] cand_addr_i,
  input logic              cand_done_i,
  input logic              gen_trig_i
);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(LINE_BYTES - 1);

  logic wb_head;
  assign wb_head = wb_valid_i && ((wb_addr_i & ~OFF_MASK) == pf_addr_i);

  AST_LINE_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_valid_i |-> ((pf_addr_i & OFF_MASK) == '0)); // R3

  AST_HEAD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pf_valid_i && !pf_ready_i && !wb_head) |=> (pf_valid_i && pf_addr_i == $past(pf_addr_i))); // R9

  AST_SQUASH_HEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pf_valid_i && !pf_ready_i && wb_head) |=> !(pf_valid_i && pf_addr_i == $past(pf_addr_i))); // R10

  AST_CAND_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cand_valid_i && !cand_done_i && !gen_trig_i) |=> (cand_valid_i && cand_addr_i == $past(cand_addr_i))); // R9
endmodule

bind stride_pf stride_pf_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .pf_valid_i(pf_valid_o), .pf_ready_i(pf_ready_i), .pf_addr_i(pf_addr_o),
  .wb_valid_i(wb_valid_i), .wb_addr_i(wb_addr_i),
  .cand_valid_i(cand_valid), .cand_addr_i(cand_addr),
  .cand_done_i(cand_done), .gen_trig_i(gen_trig)
);

// File: tb/sim_stride_pf.sv
`timescale 1ns/1ps
module sim_stride_pf;
  localparam logic [31:0] LMASK = ~32'd63;

  typedef struct packed {
    logic [31:0] pc;
    logic [31:0] addr;
    logic [31:0] stride;
    logic        issue;
  } vec_t;

  // stride training walk: P1 (set 0) by 48 bytes, P2 (set 1) by 64 then retrain
  localparam vec_t VECS [16] = '{
    '{32'h400, 32'h1000, 32'h30,   1'b0},
    '{32'h400, 32'h1030, 32'h30,   1'b0},
    '{32'h400, 32'h1060, 32'h30,   1'b0},
    '{32'h400, 32'h1090, 32'h30,   1'b1},
    '{32'h400, 32'h10C0, 32'h30,   1'b1},
    '{32'h400, 32'h10F0, 32'h30,   1'b1},
    '{32'h400, 32'h8000, 32'h30,   1'b1},
    '{32'h400, 32'h8030, 32'h30,   1'b1},
    '{32'h504, 32'h2000, 32'h40,   1'b0},
    '{32'h504, 32'h2040, 32'h40,   1'b0},
    '{32'h504, 32'h2080, 32'h40,   1'b0},
    '{32'h504, 32'h20C0, 32'h40,   1'b1},
    '{32'h504, 32'h5000, 32'h40,   1'b1},
    '{32'h504, 32'h6000, 32'h1000, 1'b0},
    '{32'h504, 32'h7000, 32'h1000, 1'b0},
    '{32'h504, 32'h8000, 32'h1000, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_miss_only = 0, cfg_data_only = 0, cfg_inst_nblk = 0, cfg_tag_pc = 0;
  logic acc_valid = 0, acc_miss = 0, acc_inst = 0, wb_valid = 0, pf_ready = 0;
  logic [31:0] acc_addr = '0, acc_pc = '0, wb_addr = '0;
  logic pf_valid, pf_pc_valid;
  logic [31:0] pf_addr, pf_pc;

  int errors = 0, checks = 0;
  int exp_n;
  logic [31:0] exp_a [8];
  logic [31:0] exp_pc;
  logic exp_pcv;

  always #2 clk = ~clk;

  stride_pf u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_miss_only_i(cfg_miss_only), .cfg_data_only_i(cfg_data_only),
    .cfg_inst_nblk_i(cfg_inst_nblk), .cfg_tag_pc_i(cfg_tag_pc),
    .acc_valid_i(acc_valid), .acc_addr_i(acc_addr), .acc_pc_i(acc_pc),
    .acc_miss_i(acc_miss), .acc_inst_i(acc_inst),
    .wb_valid_i(wb_valid), .wb_addr_i(wb_addr),
    .pf_valid_o(pf_valid), .pf_ready_i(pf_ready), .pf_addr_o(pf_addr),
    .pf_pc_o(pf_pc), .pf_pc_valid_o(pf_pc_valid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic [31:0] pc, input logic [31:0] a, input logic miss, input logic inst);
    @(negedge clk);
    acc_valid = 1; acc_pc = pc; acc_addr = a; acc_miss = miss; acc_inst = inst;
    @(negedge clk);
    acc_valid = 0;
  endtask

  task automatic set_exp2(input logic [31:0] a, input logic [31:0] s);
    logic [31:0] l1, l2;
    l1 = (a + s) & LMASK;
    l2 = (a + 2*s) & LMASK;
    exp_a[0] = l1;
    exp_a[1] = l2;
    exp_n = (l1 == l2) ? 1 : 2;
  endtask

  // wait for generation, then pull everything out of the queue
  task automatic drain(input string req);
    int n;
    logic [31:0] ga [8];
    logic [31:0] gp [8];
    logic gv [8];
    n = 0;
    repeat (4) @(negedge clk);
    pf_ready = 1;
    for (int k = 0; k < 10; k++) begin
      if (pf_valid && n < 8) begin
        ga[n] = pf_addr; gp[n] = pf_pc; gv[n] = pf_pc_valid;
        n++;
      end
      @(negedge clk);
    end
    pf_ready = 0;
    chk({req, " count"}, 32'(n), 32'(exp_n));
    for (int k = 0; k < exp_n && k < n; k++) begin
      chk({req, " addr"}, ga[k], exp_a[k]);
      chk({req, " pc_valid"}, {31'd0, gv[k]}, {31'd0, exp_pcv});
      if (exp_pcv) chk({req, " pc"}, gp[k], exp_pc);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    exp_pcv = 0; exp_pc = '0; exp_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", {31'd0, pf_valid}, 32'd0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R1 valid after reset", {31'd0, pf_valid}, 32'd0);

    // R2 R3 R4 R11: vector walk
    for (int i = 0; i < 16; i++) begin
      access(VECS[i].pc, VECS[i].addr, 1'b1, 1'b0);
      if (VECS[i].issue) set_exp2(VECS[i].addr, VECS[i].stride);
      else exp_n = 0;
      drain($sformatf("R2 R3 R4 vec%0d", i));
    end

    // R7 miss-only filter
    cfg_miss_only = 1;
    access(32'h400, 32'h8060, 1'b0, 1'b0);
    exp_n = 0; drain("R7 hit ignored");
    access(32'h400, 32'h8060, 1'b1, 1'b0);
    set_exp2(32'h8060, 32'h30); drain("R7 miss trains");
    cfg_miss_only = 0;

    // R6 next-N-lines for instruction accesses
    cfg_inst_nblk = 1;
    access(32'h900, 32'h3010, 1'b1, 1'b1);
    exp_a[0] = 32'h3040; exp_a[1] = 32'h3080; exp_n = 2;
    drain("R6 nblk");

    // R8 data-only filter
    cfg_data_only = 1;
    access(32'h900, 32'h3000, 1'b1, 1'b1);
    exp_n = 0; drain("R8 inst ignored");
    cfg_data_only = 0;

    // R9 ordering, hold and full-queue wait
    access(32'h900, 32'h5000, 1'b1, 1'b1);
    repeat (3) @(negedge clk);
    access(32'h900, 32'h6000, 1'b1, 1'b1);
    repeat (3) @(negedge clk);
    access(32'h900, 32'h7000, 1'b1, 1'b1);
    repeat (5) @(negedge clk);
    chk("R9 head valid", {31'd0, pf_valid}, 32'd1);
    chk("R9 head held", pf_addr, 32'h5040);
    exp_a[0] = 32'h5040; exp_a[1] = 32'h5080; exp_a[2] = 32'h6040;
    exp_a[3] = 32'h6080; exp_a[4] = 32'h7040; exp_a[5] = 32'h7080; exp_n = 6;
    drain("R9 fifo order");

    // R11 duplicate line suppression
    access(32'h900, 32'h5000, 1'b1, 1'b1);
    repeat (3) @(negedge clk);
    access(32'h900, 32'h5000, 1'b1, 1'b1);
    exp_a[0] = 32'h5040; exp_a[1] = 32'h5080; exp_n = 2;
    drain("R11 dup");

    // R10 writeback squash
    access(32'h900, 32'h4000, 1'b1, 1'b1);
    repeat (3) @(negedge clk);
    wb_valid = 1; wb_addr = 32'h4044;
    @(negedge clk);
    wb_valid = 0;
    exp_a[0] = 32'h4080; exp_n = 1;
    drain("R10 squash");

    // R12 PC tagging
    cfg_tag_pc = 1; exp_pcv = 1; exp_pc = 32'h0ABC;
    access(32'h0ABC, 32'h3000, 1'b1, 1'b1);
    exp_a[0] = 32'h3040; exp_a[1] = 32'h3080; exp_n = 2;
    drain("R12 pc tag");
    cfg_tag_pc = 0; exp_pcv = 0;
    cfg_inst_nblk = 0;

    // R5 LRU within set 2: PA=0x008, PB=0x108, PC=0x208
    for (int k = 0; k < 3; k++) begin
      access(32'h008, 32'h20000 + 32'(k) * 32'h100, 1'b1, 1'b0);
      exp_n = 0; drain("R5 PA train");
    end
    access(32'h008, 32'h20300, 1'b1, 1'b0);
    set_exp2(32'h20300, 32'h100); drain("R5 PA issue");
    access(32'h108, 32'h30000, 1'b1, 1'b0);
    exp_n = 0; drain("R5 PB alloc");
    access(32'h008, 32'h20400, 1'b1, 1'b0);
    set_exp2(32'h20400, 32'h100); drain("R5 PA kept");
    access(32'h208, 32'h40000, 1'b1, 1'b0);
    exp_n = 0; drain("R5 PC evicts PB");
    access(32'h108, 32'h30100, 1'b1, 1'b0);
    exp_n = 0; drain("R5 PB realloc evicts PA");
    access(32'h008, 32'h20500, 1'b1, 1'b0);
    exp_n = 0; drain("R5 PA evicted");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule